// File: doc/BRIEF.md
# UART Receive FIFO with Ageing Timer

This block sits between a UART line deserializer and the register file of a serial port. Each received character arrives on a one-cycle strobe with its parity and framing error bits. A detected line break arrives on a separate strobe. Both are stored as 16-bit words in a 32-entry receive queue. The queue head is always visible on the read port, and a read strobe removes it.

The block derives a level-based ready flag from a programmable trigger level. It also keeps four sticky status flags:
- ageing: the idle timer expired;
- wake: a character arrived;
- break: a break was seen;
- overrun: a character was lost.

Each sticky flag stays set until software clears it with a write-one-to-clear strobe. The ageing timer catches the case where a few characters sit below the trigger level and no further traffic comes to push the level over it. After eight character times without queue activity, the ageing flag rises. A character time is ten bit-time ticks.

A single interrupt output combines the ready flag and the sticky flags, each gated by its own enable.

Top module: `rxq_top`

## Requirements
- R1: The queue holds 32 entries of 16 bits. `rd_data` shows the oldest entry, or all zeros when the queue is empty. A pulse on `rd_stb` removes that entry; on an empty queue it does nothing. Entry layout: bit 15 valid, bit 14 error, bit 13 overrun, bit 12 framing error, bit 11 break, bit 10 parity error, bits 7:0 data, bits 9:8 zero.
- R2: `rx_ready` is high exactly while the number of stored entries is greater than `trig_lvl`. Levels 1 and 8 both work.
- R3: The ageing timer counts `bit_tick` pulses while the queue is non-empty and its level is at or below `trig_lvl`. On the 80th counted tick (8 characters of 10 ticks), it sets the ageing flag, `sticky_flags[0]`, at that clock edge. It then stops until the timer restarts.
- R4: An accepted push or a pop resets the ageing count to zero, and so does any cycle in which the timer is not running. Activity in the same cycle as a tick takes precedence over the tick.
- R5: Every character strobe that is not overridden by a break sets the wake flag, `sticky_flags[1]`. Reading the queue never clears it.
- R6: A break strobe sets the break flag, `sticky_flags[2]`. It pushes an entry with valid, error, framing and break set and data zero. If a character strobe arrives in the same cycle, the character is discarded and does not set the wake flag.
- R7: A push into a full queue with no pop in the same cycle is dropped and sets the overrun flag, `sticky_flags[3]`. The next accepted entry carries the overrun and error bits. A push into a full queue alongside a pop is accepted.
- R8: The entry error bit is the OR of its parity, framing, overrun and break bits.
- R9: `irq` = (`rx_ready` AND `en_ready`) OR any (`sticky_flags[i]` AND `en_mask[i]`).
- R10: While `clr_wr` is high, each sticky flag whose `clr_mask` bit is 1 is cleared. A set event in the same cycle keeps that flag set.
- R11: After reset the queue is empty, all sticky flags are 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| char_stb | input | 1 | Received-character strobe |
| char_data | input | 8 | Received character |
| char_par_err | input | 1 | Parity error of the character |
| char_frm_err | input | 1 | Framing error of the character |
| brk_stb | input | 1 | Line-break strobe |
| bit_tick | input | 1 | One pulse per bit time |
| rd_stb | input | 1 | Pop the head entry |
| rd_data | output | 16 | Head entry, zero when empty |
| trig_lvl | input | 6 | Receive trigger level |
| clr_wr | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | 4 | Sticky flags to clear |
| en_ready | input | 1 | Interrupt enable for the ready flag |
| en_mask | input | 4 | Interrupt enables for the sticky flags |
| rx_ready | output | 1 | Level above trigger |
| sticky_flags | output | 4 | {overrun, break, wake, ageing} |
| irq | output | 1 | Interrupt request |

## Verification
The hardest condition to reach from the ports is an ageing expiry that follows a timer restart. The stimulus runs ticks almost to the timeout, then inserts a pop or a push, and shows that the flag appears only a full 80 ticks after that activity. The same sequence is repeated at trigger level 8, where the level climbs while the timer is active. The overrun path needs the queue filled to exactly 32 entries. Pushes then arrive with and without a same-cycle pop, and the overrun marker is traced into the next accepted entry as it drains.

// File: rtl/rxq_pkg.sv
// Shared constants and entry formatting for the receive queue.
// Assumes an 8-bit character and a 16-bit queue word.
package rxq_pkg;
    localparam int ENT_W     = 16;
    localparam int BIT_VALID = 15;
    localparam int BIT_ERR   = 14;
    localparam int BIT_OVR   = 13;
    localparam int BIT_FRM   = 12;
    localparam int BIT_BRK   = 11;
    localparam int BIT_PAR   = 10;

    localparam int FLG_AGE  = 0;
    localparam int FLG_WAKE = 1;
    localparam int FLG_BRK  = 2;
    localparam int FLG_OVR  = 3;
    localparam int NFLG     = 4;

    // Build a queue word from a character or a break event.
    function automatic logic [ENT_W-1:0] build_entry(
        input logic       is_brk,
        input logic [7:0] data,
        input logic       par_err,
        input logic       frm_err,
        input logic       lost);
        logic [ENT_W-1:0] w;
        logic             p, f, b;
        b = is_brk;
        p = is_brk ? 1'b0 : par_err;
        f = is_brk ? 1'b1 : frm_err;
        w = '0;
        w[BIT_VALID] = 1'b1;
        w[BIT_OVR]   = lost;
        w[BIT_FRM]   = f;
        w[BIT_BRK]   = b;
        w[BIT_PAR]   = p;
        w[BIT_ERR]   = p | f | b | lost;
        w[7:0]       = is_brk ? 8'h00 : data;
        return w;
    endfunction
endpackage

// File: rtl/rxq_storage.sv
// Circular buffer holding DEPTH words. It assumes the caller only pushes
// when space exists (or a pop happens in the same cycle) and only pops
// when non-empty. It reports the head word and the fill level.
module rxq_storage #(
    parameter int DEPTH = 32,
    parameter int W     = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] level
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    // Store the incoming word at the write pointer.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    // Advance pointers and track the number of stored words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      level <= level + 1'b1;
            else if (pop && !push) level <= level - 1'b1;
        end
    end

    // The head word, valid whenever the level is non-zero.
    assign head = mem[rd_ptr];
endmodule

// File: rtl/rxq_age_timer.sv
// Idle timer: counts ticks while enabled and produces a single expiry
// pulse on the AGE_TICKS-th tick. It then holds until restarted.
// A restart has precedence over a tick.
module rxq_age_timer #(
    parameter int AGE_TICKS = 80,
    localparam int T_W = $clog2(AGE_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic tick,
    output logic expire
);
    localparam logic [T_W-1:0] LIMIT     = T_W'(AGE_TICKS);
    localparam logic [T_W-1:0] LIMIT_M1  = T_W'(AGE_TICKS - 1);

    logic [T_W-1:0] cnt;
    logic           hold0;

    assign hold0  = restart || !run;
    assign expire = !hold0 && tick && (cnt == LIMIT_M1);

    // Tick counter, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt <= '0;
        else if (hold0)                cnt <= '0;
        else if (tick && cnt != LIMIT) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rxq_flags.sv
// Bank of sticky status bits, one per lane. Set has priority over clear.
module rxq_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Hold one sticky bit.
        always_ff @(posedge clk) begin
            if (!rst_n)          flags[i] <= 1'b0;
            else if (set_vec[i]) flags[i] <= 1'b1;
            else if (clr_vec[i]) flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/rxq_top.sv
// Receive queue with ageing timer, sticky status and interrupt.
// It assumes char_stb and brk_stb are one-cycle pulses from the
// deserializer and that bit_tick pulses once per bit time.
module rxq_top #(
    parameter int DEPTH          = 32,
    parameter int TICKS_PER_CHAR = 10,
    parameter int AGE_CHARS      = 8,
    localparam int LVL_W     = $clog2(DEPTH + 1),
    localparam int AGE_TICKS = TICKS_PER_CHAR * AGE_CHARS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      char_stb,
    input  logic [7:0]                char_data,
    input  logic                      char_par_err,
    input  logic                      char_frm_err,
    input  logic                      brk_stb,
    input  logic                      bit_tick,
    input  logic                      rd_stb,
    output logic [rxq_pkg::ENT_W-1:0] rd_data,
    input  logic [LVL_W-1:0]          trig_lvl,
    input  logic                      clr_wr,
    input  logic [rxq_pkg::NFLG-1:0]  clr_mask,
    input  logic                      en_ready,
    input  logic [rxq_pkg::NFLG-1:0]  en_mask,
    output logic                      rx_ready,
    output logic [rxq_pkg::NFLG-1:0]  sticky_flags,
    output logic                      irq
);
    import rxq_pkg::*;

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic [ENT_W-1:0] head, new_ent;
    logic [LVL_W-1:0] level;
    logic             pop_ok, push_req, push_ok, drop;
    logic             lost_q, age_run, age_exp;
    logic [NFLG-1:0]  set_vec, clr_vec;

    // Queue control: a break overrides a simultaneous character.
    always_comb begin
        pop_ok   = rd_stb && (level != '0);
        push_req = brk_stb || char_stb;
        push_ok  = push_req && ((level != FULL_LVL) || pop_ok);
        drop     = push_req && !push_ok;
        new_ent  = build_entry(brk_stb, char_data, char_par_err, char_frm_err, lost_q);
    end

    // Remember a dropped push so the next stored word is marked.
    always_ff @(posedge clk) begin
        if (!rst_n)       lost_q <= 1'b0;
        else if (push_ok) lost_q <= 1'b0;
        else if (drop)    lost_q <= 1'b1;
    end

    rxq_storage #(.DEPTH(DEPTH), .W(ENT_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_ok),
        .pop   (pop_ok),
        .wdata (new_ent),
        .head  (head),
        .level (level)
    );

    assign rd_data  = (level != '0) ? head : '0;
    assign rx_ready = level > trig_lvl;
    assign age_run  = (level != '0) && (level <= trig_lvl);

    rxq_age_timer #(.AGE_TICKS(AGE_TICKS)) u_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (age_run),
        .restart (push_ok || pop_ok),
        .tick    (bit_tick),
        .expire  (age_exp)
    );

    // Collect the set and clear events for the sticky bits.
    always_comb begin
        set_vec           = '0;
        set_vec[FLG_AGE]  = age_exp;
        set_vec[FLG_WAKE] = char_stb && !brk_stb;
        set_vec[FLG_BRK]  = brk_stb;
        set_vec[FLG_OVR]  = drop;
        clr_vec           = clr_wr ? clr_mask : '0;
    end

    rxq_flags #(.N(NFLG)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flags   (sticky_flags)
    );

    assign irq = (rx_ready && en_ready) || |(sticky_flags & en_mask);
endmodule

// File: rtl/rxq_checker.sv
// Protocol checks on the receive queue, attached by bind.
module rxq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        char_stb,
    input logic        brk_stb,
    input logic        bit_tick,
    input logic        clr_wr,
    input logic [3:0]  clr_mask,
    input logic        en_ready,
    input logic        rx_ready,
    input logic [3:0]  sticky_flags,
    input logic [15:0] rd_data,
    input logic        irq
);
    // R2
    ready_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> rd_data[15]);
    // R1
    empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[15] |-> (rd_data == 16'h0000));
    // R3
    age_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sticky_flags[0]) |-> $past(bit_tick));
    // R5
    wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_flags[1] && !(clr_wr && clr_mask[1])) |=> sticky_flags[1]);
    // R6
    brk_no_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_stb && !sticky_flags[1]) |=> !sticky_flags[1]);
    // R6
    brk_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_stb |=> sticky_flags[2]);
    // R7
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sticky_flags[3]) |-> $past(char_stb || brk_stb));
    // R9
    irq_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && en_ready) |-> irq);
endmodule

bind rxq_top rxq_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .char_stb     (char_stb),
    .brk_stb      (brk_stb),
    .bit_tick     (bit_tick),
    .clr_wr       (clr_wr),
    .clr_mask     (clr_mask),
    .en_ready     (en_ready),
    .rx_ready     (rx_ready),
    .sticky_flags (sticky_flags),
    .rd_data      (rd_data),
    .irq          (irq)
);

// File: tb/rxq_top_test.sv
// Bench: behavioural queue model compared with the design every clock.
module rxq_top_test;
    localparam int DEPTH = 32;
    localparam int AGE   = 80;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        char_stb = 0, char_par_err = 0, char_frm_err = 0;
    logic [7:0]  char_data = 0;
    logic        brk_stb = 0, bit_tick = 0, rd_stb = 0, clr_wr = 0, en_ready = 0;
    logic [5:0]  trig_lvl = 1;
    logic [3:0]  clr_mask = 0, en_mask = 0;
    logic [15:0] rd_data;
    logic        rx_ready, irq;
    logic [3:0]  sticky_flags;

    always #4 clk = ~clk;

    rxq_top uut (.*);

    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;

    // Reference state
    logic [15:0] mq[$];
    int          m_tmr = 0;
    bit          m_lost = 0;
    bit [3:0]    m_flags = 0;

    always @(posedge clk) begin
        int sz;
        bit pop_ok, push_req, push_ok, run, act, expd;
        logic [15:0] ent;
        bit [3:0] setv;
        if (!rst_n) begin
            mq.delete(); m_tmr = 0; m_lost = 0; m_flags = 0;
        end else begin
            sz = mq.size();
            pop_ok = rd_stb && sz > 0;
            push_req = brk_stb || char_stb;
            push_ok = push_req && (sz < DEPTH || pop_ok);
            if (brk_stb) ent = 16'hD800 | (m_lost ? 16'h2000 : 16'h0);
            else begin
                ent = 16'h8000 | {8'h00, char_data};
                if (char_par_err) ent |= 16'h0400;
                if (char_frm_err) ent |= 16'h1000;
                if (m_lost) ent |= 16'h2000;
                if (char_par_err || char_frm_err || m_lost) ent |= 16'h4000;
            end
            run = sz > 0 && sz <= int'(trig_lvl);
            act = pop_ok || push_ok;
            expd = 0;
            if (act || !run) m_tmr = 0;
            else if (bit_tick && m_tmr < AGE) begin
                m_tmr++;
                if (m_tmr == AGE) expd = 1;
            end
            setv = 0;
            if (pop_ok) void'(mq.pop_front());
            if (push_ok) begin mq.push_back(ent); m_lost = 0; end
            else if (push_req) begin m_lost = 1; setv[3] = 1; end
            setv[0] = expd;
            setv[1] = char_stb && !brk_stb;
            setv[2] = brk_stb;
            if (clr_wr) m_flags &= ~clr_mask;
            m_flags |= setv;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [15:0] eh;
        bit er;
        eh = (mq.size() > 0) ? mq[0] : 16'h0;
        er = mq.size() > int'(trig_lvl);
        chk("R1 head word", rd_data, eh);
        chk("R2 ready", {15'h0, rx_ready}, {15'h0, er});
        chk("R3 age flag", {15'h0, sticky_flags[0]}, {15'h0, m_flags[0]});
        chk("R5 wake flag", {15'h0, sticky_flags[1]}, {15'h0, m_flags[1]});
        chk("R6 break flag", {15'h0, sticky_flags[2]}, {15'h0, m_flags[2]});
        chk("R7 overrun flag", {15'h0, sticky_flags[3]}, {15'h0, m_flags[3]});
        chk("R9 irq", {15'h0, irq}, {15'h0, (er && en_ready) || |(m_flags & en_mask)});
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        if (rst_n) compare_all();
        char_stb = 0; brk_stb = 0; rd_stb = 0; clr_wr = 0;
        char_par_err = 0; char_frm_err = 0;
    endtask

    task automatic put(input logic [7:0] d);
        char_stb = 1; char_data = d; step();
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic clear(input logic [3:0] m);
        clr_wr = 1; clr_mask = m; step();
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog all-requirements actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        steps(3);
        rst_n = 1;
        step();
        // R11 reset state
        chk("R11 empty", rd_data, 16'h0);
        chk("R11 flags", {12'h0, sticky_flags}, 16'h0);
        chk("R11 irq", {15'h0, irq}, 16'h0);

        // Ageing at trigger 1
        trig_lvl = 1;
        put(8'h41);
        bit_tick = 1;
        steps(AGE - 1);
        chk("R3 not yet expired", {15'h0, sticky_flags[0]}, 16'h0);
        step();
        chk("R3 expired at 80th tick", {15'h0, sticky_flags[0]}, 16'h1);
        steps(5);
        clear(4'b0001);
        chk("R10 age cleared", {15'h0, sticky_flags[0]}, 16'h0);

        // Restart by activity
        put(8'h42);
        chk("R2 level 2 over trigger 1", {15'h0, rx_ready}, 16'h1);
        rd_stb = 1; step();
        steps(AGE - 10);
        rd_stb = 0; put(8'h43); rd_stb = 1; step();
        steps(AGE - 2);
        chk("R4 restart delays ageing", {15'h0, sticky_flags[0]}, 16'h0);
        steps(4);
        chk("R4 expiry after restart", {15'h0, sticky_flags[0]}, 16'h1);
        bit_tick = 0;

        // Wake and break
        clear(4'b0011);
        chk("R5 wake cleared by software only", {15'h0, sticky_flags[1]}, 16'h0);
        brk_stb = 1; step();
        chk("R6 break leaves wake low", {15'h0, sticky_flags[1]}, 16'h0);
        char_stb = 1; char_data = 8'h77; brk_stb = 1; step();
        char_par_err = 1; put(8'h55);
        char_frm_err = 1; put(8'h66);
        rd_stb = 1; step();
        chk("R6 break entry", rd_data, 16'hD800);
        rd_stb = 1; step();
        rd_stb = 1; step();
        chk("R8 parity error entry", rd_data, 16'hC455);
        rd_stb = 1; step();
        chk("R8 frame error entry", rd_data, 16'hD066);
        rd_stb = 1; step();
        chk("R5 wake kept after reads", {15'h0, sticky_flags[1]}, 16'h1);

        // Fill at trigger 8 with ticks, then overrun
        trig_lvl = 8; bit_tick = 1;
        clear(4'b1111);
        for (int i = 0; i < 40; i++) put(8'(i));
        chk("R7 overrun set", {15'h0, sticky_flags[3]}, 16'h1);
        char_stb = 1; char_data = 8'hAA; rd_stb = 1; step();
        put(8'hBB);
        rd_stb = 1; step();
        put(8'hCC);
        en_ready = 1; en_mask = 4'b1000; step();
        en_ready = 0; step();
        for (int i = 0; i < 36; i++) begin rd_stb = 1; step(); end
        steps(AGE + 5);

        // Interrupt enables and set-versus-clear
        for (int e = 0; e < 16; e++) begin en_mask = 4'(e); step(); end
        put(8'h11);
        steps(AGE + 2);
        clr_wr = 1; clr_mask = 4'b0010; put(8'h12);
        chk("R10 set wins over clear", {15'h0, sticky_flags[1]}, 16'h1);
        for (int e = 0; e < 16; e++) begin en_mask = 4'(e); step(); end
        clear(4'b1111);
        rd_stb = 1; step(); rd_stb = 1; step();
        trig_lvl = 0; put(8'h13); en_ready = 1; step();
        steps(5);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule